// File: doc/BRIEF.md
# Dual-Port RAM With Mailbox Interrupts

This block is a word-organised memory with two ports of equal rank, called left and right. Each port has its own address, write data, read data, chip select, output enable, write strobe and two byte-lane enables. Both ports can reach every word in the same clock cycle, including the same word. All port activity is sampled on one rising clock edge. Read data comes from a register one cycle after the request.

The two highest words double as message slots between the ports. The top word belongs to the right port and the word just below it belongs to the left port. A write by one port into the other port's slot pulls that port's active-low interrupt low. The owning port releases its interrupt by reading its own slot. Software on each side can therefore post a word together with a notification, and the receiver acknowledges it when it fetches the word.

The width is a parameter (16 or 18 bits), split into an upper and a lower half lane. The depth is two to the power of the address-width parameter.

Top module: `dpram_mbox`

## Requirements
- R1: While reset is held and right after it, both interrupt outputs are high, both read-drive flags are low and both read-data buses are zero.
- R2: A word written by either port can be read back by either port. When ce_n is low, wr_n is high and oe_n is low at a rising edge, the port's rdata carries the word at its address and rdrive is high from that edge until the next one.
- R3: With wr_n low and ce_n low, ub_n low writes bits [DATA_W-1:DATA_W/2] and lb_n low writes bits [DATA_W/2-1:0]. With both lane enables high the word is unchanged.
- R4: With ce_n high the port writes nothing, and after that edge its rdrive is low and its rdata is zero (the high-impedance state).
- R5: A read taken with oe_n high leaves rdrive low and rdata zero for the next cycle, although the access itself still counts as a read.
- R6: Both ports can read the same word in one cycle and both receive it. A read of a word that the other port writes in the same cycle returns the old contents.
- R7: When both ports write the same word in one cycle, every lane the left port writes takes the left value, and lanes only the right port writes take the right value.
- R8: A left-port write with at least one lane enabled to address DEPTH-1 drives r_irq_n low from the following edge.
- R9: A right-port write with at least one lane enabled to address DEPTH-2 drives l_irq_n low from the following edge.
- R10: A port's interrupt returns high after an edge where that port reads its own mailbox (ce_n low, wr_n high, whatever oe_n is). If a set and a clear for the same interrupt meet in one cycle, the set wins.
- R11: Nothing else moves an interrupt: a port writing its own mailbox, the other port reading it, and accesses to any other address leave both interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| l_ce_n | input | 1 | Left chip select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_wr_n | input | 1 | Left write strobe, low writes, high reads |
| l_ub_n | input | 1 | Left upper-lane enable, active low |
| l_lb_n | input | 1 | Left lower-lane enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, zero when not driven |
| l_rdrive | output | 1 | Left read data valid and driven |
| l_irq_n | output | 1 | Left mailbox interrupt, active low |
| r_ce_n | input | 1 | Right chip select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_wr_n | input | 1 | Right write strobe, low writes, high reads |
| r_ub_n | input | 1 | Right upper-lane enable, active low |
| r_lb_n | input | 1 | Right lower-lane enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, zero when not driven |
| r_rdrive | output | 1 | Right read data valid and driven |
| r_irq_n | output | 1 | Right mailbox interrupt, active low |

## Verification
Each port result is due exactly one rising edge after the request that causes it. Read data and rdrive follow from one register stage. A write changes the array at that edge and so shows up in a read issued in the next cycle. An interrupt moves at the edge that samples the causing write or read. The bench applies each request just after a falling edge and compares outputs at the following falling edge, half a period after the register has loaded. The array contents and the interrupt levels are kept as a model in the bench. Every check counts the single register stage between request and result.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;
  localparam int NUM_SIDES = 2;
  localparam int NUM_LANES = 2;
endpackage

// File: rtl/dpram_port_dec.sv
module dpram_port_dec #(
  parameter int ADDR_W = 6,
  parameter int NUM_LANES = 2,
  parameter logic [ADDR_W-1:0] OWN_BOX = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
  input  logic                 ce_n,
  input  logic                 oe_n,
  input  logic                 wr_n,
  input  logic                 ub_n,
  input  logic                 lb_n,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_LANES-1:0] wr_lane,
  output logic                 rd_en,
  output logic                 drive_nxt,
  output logic                 own_hit,
  output logic                 peer_hit
);
  logic sel;
  always_comb begin
    sel       = ~ce_n;
    wr_lane   = '0;
    wr_lane[NUM_LANES-1] = sel & ~wr_n & ~ub_n;
    wr_lane[0]           = sel & ~wr_n & ~lb_n;
    rd_en     = sel & wr_n;
    drive_nxt = sel & wr_n & ~oe_n;
    own_hit   = (addr == OWN_BOX);
    peer_hit  = (addr == PEER_BOX);
  end
endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int NUM_LANES = 2,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int LANE_W = DATA_W / NUM_LANES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LANES-1:0] wl_lane,
  input  logic                 rd_l,
  input  logic                 drv_l_nxt,
  input  logic [ADDR_W-1:0]    a_l,
  input  logic [DATA_W-1:0]    wd_l,
  input  logic [NUM_LANES-1:0] wr_lane,
  input  logic                 rd_r,
  input  logic                 drv_r_nxt,
  input  logic [ADDR_W-1:0]    a_r,
  input  logic [DATA_W-1:0]    wd_r,
  output logic [DATA_W-1:0]    q_l,
  output logic                 drv_l,
  output logic [DATA_W-1:0]    q_r,
  output logic                 drv_r
);
  logic [NUM_LANES-1:0][LANE_W-1:0] mem [DEPTH];
  logic [NUM_LANES-1:0][LANE_W-1:0] wd_l_v, wd_r_v;
  logic [DATA_W-1:0] q_l_q, q_r_q;
  logic drv_l_q, drv_r_q;

  assign wd_l_v = wd_l;
  assign wd_r_v = wd_r;

  // Array write: right first, left last so left owns shared lanes.
  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_LANES; b++) begin
      if (wr_lane[b]) mem[a_r][b] <= wd_r_v[b];
    end
    for (int b = 0; b < NUM_LANES; b++) begin
      if (wl_lane[b]) mem[a_l][b] <= wd_l_v[b];
    end
  end

  // Read data registers, clock-enabled by each port's read request.
  always_ff @(posedge clk) begin
    if (rd_l) q_l_q <= mem[a_l];
    if (rd_r) q_r_q <= mem[a_r];
  end

  // Output-drive flags carry reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_l_q <= 1'b0;
      drv_r_q <= 1'b0;
    end else begin
      drv_l_q <= drv_l_nxt;
      drv_r_q <= drv_r_nxt;
    end
  end

  assign drv_l = drv_l_q;
  assign drv_r = drv_r_q;
  assign q_l   = drv_l_q ? q_l_q : '0;
  assign q_r   = drv_r_q ? q_r_q : '0;
endmodule

// File: rtl/dpram_mbox_irq.sv
module dpram_mbox_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_n
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_req) pend_d = 1'b0;
    if (set_req) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign irq_n = ~pend_q;
endmodule

// File: rtl/dpram_mbox.sv
module dpram_mbox
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce_n,
  input  logic              l_oe_n,
  input  logic              l_wr_n,
  input  logic              l_ub_n,
  input  logic              l_lb_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rdrive,
  output logic              l_irq_n,
  input  logic              r_ce_n,
  input  logic              r_oe_n,
  input  logic              r_wr_n,
  input  logic              r_ub_n,
  input  logic              r_lb_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rdrive,
  output logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] BOX_R = '1;
  localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

  // Reset synchroniser: asserts at once, releases after two edges.
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [NUM_SIDES-1:0]              ce_n, oe_n, wr_n, ub_n, lb_n;
  logic [ADDR_W-1:0]                 addr [NUM_SIDES];
  logic [NUM_LANES-1:0]              wr_lane [NUM_SIDES];
  logic [NUM_SIDES-1:0]              rd_en, drive_nxt, own_hit, peer_hit, irq_n;

  assign ce_n = {r_ce_n, l_ce_n};
  assign oe_n = {r_oe_n, l_oe_n};
  assign wr_n = {r_wr_n, l_wr_n};
  assign ub_n = {r_ub_n, l_ub_n};
  assign lb_n = {r_lb_n, l_lb_n};
  assign addr[SIDE_L] = l_addr;
  assign addr[SIDE_R] = r_addr;

  for (genvar p = 0; p < NUM_SIDES; p++) begin : g_side
    localparam int OTHER = NUM_SIDES - 1 - p;
    dpram_port_dec #(
      .ADDR_W   (ADDR_W),
      .NUM_LANES(NUM_LANES),
      .OWN_BOX  ((p == 0) ? BOX_L : BOX_R),
      .PEER_BOX ((p == 0) ? BOX_R : BOX_L)
    ) u_dec (
      .ce_n     (ce_n[p]),
      .oe_n     (oe_n[p]),
      .wr_n     (wr_n[p]),
      .ub_n     (ub_n[p]),
      .lb_n     (lb_n[p]),
      .addr     (addr[p]),
      .wr_lane  (wr_lane[p]),
      .rd_en    (rd_en[p]),
      .drive_nxt(drive_nxt[p]),
      .own_hit  (own_hit[p]),
      .peer_hit (peer_hit[p])
    );

    dpram_mbox_irq u_irq (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .set_req((|wr_lane[OTHER]) & peer_hit[OTHER]),
      .clr_req(rd_en[p] & own_hit[p]),
      .irq_n  (irq_n[p])
    );
  end

  dpram_store #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_LANES(NUM_LANES)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wl_lane  (wr_lane[SIDE_L]),
    .rd_l     (rd_en[SIDE_L]),
    .drv_l_nxt(drive_nxt[SIDE_L]),
    .a_l      (l_addr),
    .wd_l     (l_wdata),
    .wr_lane  (wr_lane[SIDE_R]),
    .rd_r     (rd_en[SIDE_R]),
    .drv_r_nxt(drive_nxt[SIDE_R]),
    .a_r      (r_addr),
    .wd_r     (r_wdata),
    .q_l      (l_rdata),
    .drv_l    (l_rdrive),
    .q_r      (r_rdata),
    .drv_r    (r_rdrive)
  );

  assign l_irq_n = irq_n[SIDE_L];
  assign r_irq_n = irq_n[SIDE_R];
endmodule

// File: rtl/dpram_mbox_chk.sv
module dpram_mbox_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_ce_n,
  input logic              l_oe_n,
  input logic              l_wr_n,
  input logic              l_ub_n,
  input logic              l_lb_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_rdrive,
  input logic              l_irq_n,
  input logic              r_ce_n,
  input logic              r_oe_n,
  input logic              r_wr_n,
  input logic              r_ub_n,
  input logic              r_lb_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_rdrive,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] TOP = '1;
  localparam logic [ADDR_W-1:0] NXT = TOP - 1'b1;

  logic l_post, r_post, l_take, r_take;
  assign l_post = !l_ce_n && !l_wr_n && !(l_ub_n && l_lb_n) && (l_addr == TOP);
  assign r_post = !r_ce_n && !r_wr_n && !(r_ub_n && r_lb_n) && (r_addr == NXT);
  assign r_take = !r_ce_n && r_wr_n && (r_addr == TOP);
  assign l_take = !l_ce_n && l_wr_n && (l_addr == NXT);

  assert_read_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && l_wr_n && !l_oe_n) |=> l_rdrive);
  assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    r_ce_n |=> !r_rdrive);
  assert_oe_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && l_wr_n && l_oe_n) |=> !l_rdrive);
  assert_right_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    l_post |=> !r_irq_n);
  assert_left_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    r_post |=> !l_irq_n);
  assert_right_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (r_take && !l_post) |=> r_irq_n);
  assert_left_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (l_take && !r_post) |=> l_irq_n);
  assert_right_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_post && !r_take) |=> $stable(r_irq_n));
  assert_left_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_post && !l_take) |=> $stable(l_irq_n));
endmodule

bind dpram_mbox dpram_mbox_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .l_ce_n  (l_ce_n),
  .l_oe_n  (l_oe_n),
  .l_wr_n  (l_wr_n),
  .l_ub_n  (l_ub_n),
  .l_lb_n  (l_lb_n),
  .l_addr  (l_addr),
  .l_rdrive(l_rdrive),
  .l_irq_n (l_irq_n),
  .r_ce_n  (r_ce_n),
  .r_oe_n  (r_oe_n),
  .r_wr_n  (r_wr_n),
  .r_ub_n  (r_ub_n),
  .r_lb_n  (r_lb_n),
  .r_addr  (r_addr),
  .r_rdrive(r_rdrive),
  .r_irq_n (r_irq_n)
);

// File: tb/sim_dpram_mbox.sv
module sim_dpram_mbox;
  localparam int AW = 4;
  localparam int DW = 18;
  localparam int DEP = 1 << AW;
  localparam int HW = DW / 2;
  localparam logic [AW-1:0] BOXR = AW'(DEP - 1);
  localparam logic [AW-1:0] BOXL = AW'(DEP - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic l_ce_n, l_oe_n, l_wr_n, l_ub_n, l_lb_n;
  logic r_ce_n, r_oe_n, r_wr_n, r_ub_n, r_lb_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_rdrive, r_rdrive, l_irq_n, r_irq_n;

  dpram_mbox #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_wr_n(l_wr_n), .l_ub_n(l_ub_n), .l_lb_n(l_lb_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rdrive(l_rdrive), .l_irq_n(l_irq_n),
    .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_wr_n(r_wr_n), .r_ub_n(r_ub_n), .r_lb_n(r_lb_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rdrive(r_rdrive), .r_irq_n(r_irq_n)
  );

  int total = 0;
  int bad = 0;
  logic [DW-1:0] model [DEP];
  logic [DW-1:0] old_v;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drv_l(input logic ce, oe, wr, ub, lb, input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce_n = ce; l_oe_n = oe; l_wr_n = wr; l_ub_n = ub; l_lb_n = lb; l_addr = a; l_wdata = d;
  endtask

  task automatic drv_r(input logic ce, oe, wr, ub, lb, input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce_n = ce; r_oe_n = oe; r_wr_n = wr; r_ub_n = ub; r_lb_n = lb; r_addr = a; r_wdata = d;
  endtask

  task automatic idle;
    drv_l(1, 1, 1, 1, 1, '0, '0);
    drv_r(1, 1, 1, 1, 1, '0, '0);
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Model of one port write: lanes selected by active-low enables.
  task automatic mwr(input logic [AW-1:0] a, input logic ub, lb, input logic [DW-1:0] d);
    if (!ub) model[a][DW-1:HW] = d[DW-1:HW];
    if (!lb) model[a][HW-1:0] = d[HW-1:0];
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 4639 + k * 70001 + 677) % (1 << DW));
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {l_irq_n, r_irq_n, l_rdrive, r_rdrive}, 4'b1100);
    check("R1", l_rdata | r_rdata, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1", {l_irq_n, r_irq_n, l_rdrive, r_rdrive}, 4'b1100);

    // R2: left fills every word, right reads every word
    for (int a = 0; a < DEP; a++) begin
      drv_l(0, 1, 0, 0, 0, AW'(a), pat(a, 1));
      mwr(AW'(a), 0, 0, pat(a, 1));
      tick();
    end
    idle();
    // R8: left wrote right's box; R11: left writing its own box raised nothing
    check("R8", r_irq_n, 0);
    check("R11", l_irq_n, 1);
    for (int a = 0; a < DEP; a++) begin
      drv_r(0, 0, 1, 1, 1, AW'(a), '0);
      tick();
      check("R2", {r_rdrive, r_rdata}, {1'b1, model[a]});
      if (a == int'(BOXL)) check("R11", l_irq_n, 1);
    end
    idle();
    check("R10", r_irq_n, 1);

    // R3: right writes with varied lanes, left reads back
    for (int a = 0; a < DEP; a++) begin
      logic ub = (a % 3 == 2);
      logic lb = (a % 3 == 1);
      drv_r(0, 1, 0, ub, lb, AW'(a), pat(a, 2));
      mwr(AW'(a), ub, lb, pat(a, 2));
      tick();
    end
    idle();
    check("R9", l_irq_n, 0);
    check("R11", r_irq_n, 1);
    for (int a = 0; a < DEP; a++) begin
      drv_l(0, 0, 1, 1, 1, AW'(a), '0);
      tick();
      check("R3", {l_rdrive, l_rdata}, {1'b1, model[a]});
    end
    idle();
    check("R10", l_irq_n, 1);

    // R3: no lane enabled leaves the word alone
    drv_r(0, 1, 0, 1, 1, 4'd3, ~model[3]);
    tick();
    drv_r(0, 0, 1, 1, 1, 4'd3, '0);
    tick();
    check("R3", r_rdata, model[3]);

    // R4: deselected write and read
    drv_l(1, 0, 0, 0, 0, 4'd4, ~model[4]);
    tick();
    check("R4", {l_rdrive, l_rdata}, '0);
    drv_l(1, 0, 1, 1, 1, 4'd4, '0);
    tick();
    check("R4", {l_rdrive, l_rdata}, '0);
    drv_l(0, 0, 1, 1, 1, 4'd4, '0);
    tick();
    check("R4", l_rdata, model[4]);

    // R5: output enable high during a read
    drv_l(0, 1, 1, 1, 1, 4'd2, '0);
    tick();
    check("R5", {l_rdrive, l_rdata}, '0);
    idle();

    // R6: both read the same word
    drv_l(0, 0, 1, 1, 1, 4'd5, '0);
    drv_r(0, 0, 1, 1, 1, 4'd5, '0);
    tick();
    check("R6", l_rdata, model[5]);
    check("R6", r_rdata, model[5]);
    // R6: read while the other port writes the same word
    old_v = model[6];
    drv_l(0, 0, 1, 1, 1, 4'd6, '0);
    drv_r(0, 1, 0, 0, 0, 4'd6, pat(6, 3));
    mwr(4'd6, 0, 0, pat(6, 3));
    tick();
    check("R6", l_rdata, old_v);
    drv_r(1, 1, 1, 1, 1, '0, '0);
    tick();
    check("R6", l_rdata, model[6]);

    // R7: full collision, left wins
    drv_l(0, 1, 0, 0, 0, 4'd7, pat(7, 4));
    drv_r(0, 1, 0, 0, 0, 4'd7, pat(7, 5));
    mwr(4'd7, 0, 0, pat(7, 5));
    mwr(4'd7, 0, 0, pat(7, 4));
    tick();
    // R7: left upper only, right both lanes
    drv_l(0, 1, 0, 0, 1, 4'd8, pat(8, 6));
    drv_r(0, 1, 0, 0, 0, 4'd8, pat(8, 7));
    mwr(4'd8, 0, 0, pat(8, 7));
    mwr(4'd8, 0, 1, pat(8, 6));
    tick();
    drv_l(0, 0, 1, 1, 1, 4'd7, '0);
    drv_r(0, 0, 1, 1, 1, 4'd8, '0);
    tick();
    check("R7", l_rdata, pat(7, 4));
    check("R7", r_rdata, {pat(8, 6)[DW-1:HW], pat(8, 7)[HW-1:0]});
    idle();

    // R10: set and clear meet, set wins
    drv_l(0, 1, 0, 1, 0, BOXR, pat(9, 8));
    tick();
    check("R8", r_irq_n, 0);
    drv_r(0, 0, 1, 1, 1, BOXR, '0);
    tick();
    check("R10", r_irq_n, 0);
    // R11: left reading the right box leaves r_irq low
    drv_r(1, 1, 1, 1, 1, '0, '0);
    drv_l(0, 0, 1, 1, 1, BOXR, '0);
    tick();
    check("R11", r_irq_n, 0);
    // R10: clear with oe_n high
    drv_l(1, 1, 1, 1, 1, '0, '0);
    drv_r(0, 1, 1, 1, 1, BOXR, '0);
    tick();
    check("R10", r_irq_n, 1);
    // R9 with upper lane only, then R10 left clear
    drv_r(0, 1, 0, 0, 1, BOXL, pat(10, 9));
    tick();
    check("R9", l_irq_n, 0);
    drv_r(1, 1, 1, 1, 1, '0, '0);
    drv_l(0, 1, 1, 1, 1, BOXL, '0);
    tick();
    check("R10", l_irq_n, 1);
    // R11: box write with no lane enabled raises nothing
    drv_l(1, 1, 1, 1, 1, '0, '0);
    drv_r(0, 1, 0, 1, 1, BOXL, '0);
    tick();
    check("R11", l_irq_n, 1);
    idle();
    tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule